// File: doc/BRIEF.md
# IPMI BT Mailbox, BMC-Side Register Interface

This block is the BMC-facing half of an IPMI Block Transfer mailbox. BMC firmware reaches it through a byte-addressed register port. Through that port it can:
- drain a pending host request one byte at a time, with a length byte ahead of the payload;
- stack a response one byte at a time into a 64-byte send buffer;
- drive the handshake bits of a control register.

A host-side byte stream loads a framed request into the receive buffer and raises host-to-BMC attention. When firmware signals BMC-to-host attention, the send buffer leaves the block as a byte stream on the emit port. The sequence id travels beside that stream.

The block also holds two configuration words, an interrupt-enable word, a write-to-toggle interrupt status word and an interrupt mask word. A single interrupt line is raised when a request lands while enabled. Register reads are combinational, so `reg_rdata` is valid in the same cycle as `reg_rd`. Any side effect of a read takes place at the clock edge that ends that cycle.

Top module: `bt_mbox`

## Requirements
- R1: After reset every mapped register reads 0, `irq` is low, `ld_ready` is high and `em_valid` is low. The first data-port read returns a length of 0.
- R2: The word offsets 0x00, 0x04, 0x0C and 0x18 store the full 32-bit written value and read it back. Any other offset that is not 0x08, 0x10 or 0x14 (including unaligned ones) reads 0, and writes to it change nothing.
- R3: A write to offset 0x08 XORs the written value into the status word and deasserts `irq`.
- R4: Host load behaviour:
  - A host stream whose bytes are accepted on `ld_valid && ld_ready`, ending with `ld_last`, is stored in arrival order (command, sequence id, rest). The receive length becomes the byte count, capped at 64, and later bytes are dropped.
  - A load sets control bit 2 and status bit 0, and asserts `irq` when bit 0 of offset 0x04 is set.
  - `ld_ready` is low whenever control bit 7 is set.
- R5: A host stream of a single byte is rejected. The length, control bit 2, the status word and `irq` keep their values.
- R6: A read of offset 0x14 has these effects:
  - Right after a read-pointer clear it returns the receive length.
  - Following reads return the stored bytes in order.
  - Once the length is used up, reads return 0.
- R7: A write to control offset 0x10 acts on only the first set bit in the order bit 0, bit 1, bit 2, bit 7, bit 3:
  - bit 0 empties the send buffer;
  - bit 1 rewinds the read pointer;
  - bit 2 clears host-to-BMC attention;
  - bit 7 toggles BMC busy;
  - bit 3 starts an emit.
- R8: After every control write that leaves bit 7 clear, the receive length becomes 0. While bit 7 stays set, the length is kept.
- R9: A write to offset 0x14 appends the low byte of the written value to the send buffer. Writes made once 64 bytes are held are dropped.
- R10: Clearing the write pointer empties the send buffer, so a following emit streams no byte.
- R11: An emit works as follows:
  - While it runs, control bits 3 and 6 read 1. Both clear after the final byte is accepted.
  - For a send buffer of n ≥ 3 bytes, `em_seq` carries byte 2. The stream carries byte 1, then bytes 3 to n-1 (n-2 bytes), with `em_last` on the final one.
  - The emit leaves byte 1 copied into slot 2 of the buffer.
  - With n ≤ 2, no byte is streamed.
- R12: While `em_valid` is high and `em_ready` is low, `em_valid` stays high and `em_data` holds.
- R13: A control write whose only set bits are among 4, 5 and 6 leaves the control bits unchanged, apart from the R8 length rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset in the register window |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, same cycle |
| ld_valid | input | 1 | Host request byte valid |
| ld_ready | output | 1 | Block accepts a host byte |
| ld_data | input | 8 | Host request byte |
| ld_last | input | 1 | Final byte of the host request |
| em_valid | output | 1 | Emitted byte valid |
| em_ready | input | 1 | Consumer accepts emitted byte |
| em_data | output | 8 | Emitted byte |
| em_last | output | 1 | Final emitted byte |
| em_seq | output | 8 | Sequence id of the emitted message |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is the copy of byte 1 into slot 2 at emit start. That copy only shows on a second emit of the same buffer, so the stimulus emits one response twice without clearing the write pointer and expects the sequence id to change.

Overflow on both buffers also takes deliberate effort:
- 70-byte host streams check that the receive length stops at 64.
- 70 data-port writes check that only 62 bytes are emitted.

The priority chain is exercised with control words that set several bits at once.

// File: rtl/bt_mbox_pkg.sv
// Shared offsets, control-bit positions and the control-write decoder
// of the BT mailbox. Assumes a byte-addressed window of 32-bit words.
package bt_mbox_pkg;

    localparam logic [4:0] OFS_CFG0  = 5'h00;
    localparam logic [4:0] OFS_IEN   = 5'h04;
    localparam logic [4:0] OFS_IST   = 5'h08;
    localparam logic [4:0] OFS_CFG3  = 5'h0C;
    localparam logic [4:0] OFS_CTRL  = 5'h10;
    localparam logic [4:0] OFS_DATA  = 5'h14;
    localparam logic [4:0] OFS_IMASK = 5'h18;

    localparam int CB_CLR_WR = 0;
    localparam int CB_CLR_RD = 1;
    localparam int CB_H2B    = 2;
    localparam int CB_B2H    = 3;
    localparam int CB_SMS    = 4;
    localparam int CB_OEM    = 5;
    localparam int CB_HBUSY  = 6;
    localparam int CB_BBUSY  = 7;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_CLR_WR,
        ACT_CLR_RD,
        ACT_ACK_H2B,
        ACT_TOG_BBUSY,
        ACT_EMIT
    } ctrl_act_e;

    // Only the highest-priority handled bit of a control write acts.
    function automatic ctrl_act_e ctrl_decode(input logic [7:0] w);
        if (w[CB_CLR_WR])      return ACT_CLR_WR;
        else if (w[CB_CLR_RD]) return ACT_CLR_RD;
        else if (w[CB_H2B])    return ACT_ACK_H2B;
        else if (w[CB_BBUSY])  return ACT_TOG_BBUSY;
        else if (w[CB_B2H])    return ACT_EMIT;
        else                   return ACT_NONE;
    endfunction

endpackage

// File: rtl/bt_rx_buf.sv
// Receive side: stores a host request stream and serves it to the BMC
// one byte per data-port read, length byte first.
// Assumes rd_pop and rd_rewind never arrive in the same cycle.
module bt_rx_buf #(
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic       ld_valid,
    input  logic [7:0] ld_data,
    input  logic       ld_last,
    input  logic       rd_pop,
    input  logic       rd_rewind,
    input  logic       len_zero,
    output logic [7:0] rd_byte,
    output logic       load_ok
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [LEN_W-1:0] wcnt;
    logic [LEN_W-1:0] rlen;
    logic [LEN_W-1:0] ridx;
    logic             rpre;
    logic             acc;
    logic             room;
    logic [LEN_W-1:0] nbytes;

    assign acc     = ld_valid && ld_en;
    assign room    = wcnt < LEN_W'(DEPTH);
    assign nbytes  = room ? wcnt + LEN_W'(1) : wcnt;
    assign load_ok = acc && ld_last && (nbytes >= LEN_W'(2));

    // Request storage: bytes beyond the buffer are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (acc && room) begin
            mem[wcnt[IDX_W-1:0]] <= ld_data;
        end
    end

    // Stream position within the incoming request.
    always_ff @(posedge clk) begin
        if (!rst_n)   wcnt <= '0;
        else if (acc) wcnt <= ld_last ? '0 : nbytes;
    end

    // Receive length: a finished load wins over a control-write reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        rlen <= '0;
        else if (load_ok)  rlen <= nbytes;
        else if (len_zero) rlen <= '0;
    end

    // Read pointer, with a flag for the position before the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpre <= 1'b1;
            ridx <= '0;
        end else if (rd_rewind) begin
            rpre <= 1'b1;
        end else if (rd_pop) begin
            if (rpre) begin
                rpre <= 1'b0;
                ridx <= '0;
            end else if (ridx < rlen) begin
                ridx <= ridx + LEN_W'(1);
            end
        end
    end

    // Byte presented at the data port.
    always_comb begin
        if (rpre)             rd_byte = 8'(rlen);
        else if (ridx < rlen) rd_byte = mem[ridx[IDX_W-1:0]];
        else                  rd_byte = 8'h00;
    end

    p_len_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop && rpre && !rd_rewind |=> !rpre && (ridx == '0))
        else $error("R6: length read did not advance the pointer");

    p_reject_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ld_last && (wcnt == '0) && !len_zero |=> $stable(rlen))
        else $error("R5: one-byte request changed the length");

endmodule

// File: rtl/bt_tx_buf.sv
// Send side: collects response bytes from the BMC and streams them out
// on an emit request, lifting byte 2 out as the sequence id.
// Assumes DEPTH >= 3 and one register operation per cycle.
module bt_tx_buf #(
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       clear,
    input  logic       emit_go,
    input  logic       em_ready,
    output logic       em_valid,
    output logic [7:0] em_data,
    output logic       em_last,
    output logic [7:0] em_seq,
    output logic       emitting
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [LEN_W-1:0] slen;
    logic [LEN_W-1:0] pos;
    logic             start;
    logic             room;

    assign room     = slen < LEN_W'(DEPTH);
    assign start    = emit_go && !emitting;
    assign em_valid = emitting && (pos < slen);
    assign em_data  = mem[pos[IDX_W-1:0]];
    assign em_last  = pos == (slen - LEN_W'(1));

    // Buffer contents: append, wipe, and the slot-2 copy at emit start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push && room) mem[slen[IDX_W-1:0]] <= push_byte;
            if (start)        mem[2] <= mem[1];
        end
    end

    // Fill level; pushes into a full buffer are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  slen <= '0;
        else if (push && room) slen <= slen + LEN_W'(1);
    end

    // Emit sequencer: walks slots 2..slen-1 under the ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emitting <= 1'b0;
            pos      <= '0;
            em_seq   <= '0;
        end else if (start) begin
            emitting <= 1'b1;
            pos      <= LEN_W'(2);
            em_seq   <= mem[2];
        end else if (emitting) begin
            if (em_valid && em_ready) begin
                pos <= pos + LEN_W'(1);
                if (em_last) emitting <= 1'b0;
            end else if (!em_valid) begin
                emitting <= 1'b0;
            end
        end
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        em_valid && !em_ready && !clear |=> em_valid && $stable(em_data))
        else $error("R12: emitted byte changed while stalled");

    p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push && !room && !clear |=> slen == LEN_W'(DEPTH))
        else $error("R9: push into a full buffer changed the fill");

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> slen == '0)
        else $error("R10: write-pointer clear left bytes");

    p_last_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        em_valid && em_ready && em_last |=> !em_valid && !emitting)
        else $error("R11: emit continued past the final byte");

endmodule

// File: rtl/bt_mbox.sv
// BT mailbox top: register window decode, control handshake bits,
// configuration and interrupt words, and the interrupt line.
// Assumes reg_wr and reg_rd are not raised together.
module bt_mbox
    import bt_mbox_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [7:0]        ld_data,
    input  logic              ld_last,
    output logic              em_valid,
    input  logic              em_ready,
    output logic [7:0]        em_data,
    output logic              em_last,
    output logic [7:0]        em_seq,
    output logic              irq
);
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] cfg0, ien, ist, cfg3, imask;
    logic              h2b, bbusy, bbusy_nx, irq_q;
    logic              wr_cfg0, wr_ien, wr_ist, wr_cfg3, wr_imask;
    logic              wr_ctrl, wr_data, rd_data, len_zero;
    logic              load_ok, emitting;
    logic [7:0]        rx_byte, ctrl_rd;
    ctrl_act_e         act;

    assign wr_cfg0  = reg_wr && (reg_addr == ADDR_W'(OFS_CFG0));
    assign wr_ien   = reg_wr && (reg_addr == ADDR_W'(OFS_IEN));
    assign wr_ist   = reg_wr && (reg_addr == ADDR_W'(OFS_IST));
    assign wr_cfg3  = reg_wr && (reg_addr == ADDR_W'(OFS_CFG3));
    assign wr_imask = reg_wr && (reg_addr == ADDR_W'(OFS_IMASK));
    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wr_data  = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));
    assign rd_data  = reg_rd && (reg_addr == ADDR_W'(OFS_DATA));

    assign act      = wr_ctrl ? ctrl_decode(reg_wdata[7:0]) : ACT_NONE;
    assign bbusy_nx = (act == ACT_TOG_BBUSY) ? ~bbusy : bbusy;
    assign len_zero = wr_ctrl && !bbusy_nx;
    assign ld_ready = ~bbusy;
    assign irq      = irq_q;

    bt_rx_buf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_ready),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .ld_last   (ld_last),
        .rd_pop    (rd_data),
        .rd_rewind (act == ACT_CLR_RD),
        .len_zero  (len_zero),
        .rd_byte   (rx_byte),
        .load_ok   (load_ok)
    );

    bt_tx_buf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_data),
        .push_byte (reg_wdata[7:0]),
        .clear     (act == ACT_CLR_WR),
        .emit_go   (act == ACT_EMIT),
        .em_ready  (em_ready),
        .em_valid  (em_valid),
        .em_data   (em_data),
        .em_last   (em_last),
        .em_seq    (em_seq),
        .emitting  (emitting)
    );

    // Plain storage words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0  <= '0;
            ien   <= '0;
            cfg3  <= '0;
            imask <= '0;
        end else begin
            if (wr_cfg0)  cfg0  <= reg_wdata;
            if (wr_ien)   ien   <= reg_wdata;
            if (wr_cfg3)  cfg3  <= reg_wdata;
            if (wr_imask) imask <= reg_wdata;
        end
    end

    // Status word: XOR on write, bit 0 set by a completed load.
    always_ff @(posedge clk) begin
        if (!rst_n) ist <= '0;
        else        ist <= (wr_ist ? ist ^ reg_wdata : ist)
                           | (load_ok ? DATA_W'(1) : '0);
    end

    // Handshake bits: a load raises attention ahead of an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2b   <= 1'b0;
            bbusy <= 1'b0;
        end else begin
            bbusy <= bbusy_nx;
            if (load_ok)                 h2b <= 1'b1;
            else if (act == ACT_ACK_H2B) h2b <= 1'b0;
        end
    end

    // Interrupt line: set by an enabled load, dropped by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq_q <= 1'b0;
        else if (load_ok && ien[0]) irq_q <= 1'b1;
        else if (wr_ist)            irq_q <= 1'b0;
    end

    // Control word as seen by firmware.
    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[CB_BBUSY]  = bbusy;
        ctrl_rd[CB_HBUSY]  = emitting;
        ctrl_rd[CB_OEM]    = 1'b0;
        ctrl_rd[CB_SMS]    = 1'b0;
        ctrl_rd[CB_B2H]    = emitting;
        ctrl_rd[CB_H2B]    = h2b;
    end

    // Register read multiplexer; unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CFG0))       reg_rdata = cfg0;
        else if (reg_addr == ADDR_W'(OFS_IEN))   reg_rdata = ien;
        else if (reg_addr == ADDR_W'(OFS_IST))   reg_rdata = ist;
        else if (reg_addr == ADDR_W'(OFS_CFG3))  reg_rdata = cfg3;
        else if (reg_addr == ADDR_W'(OFS_CTRL))  reg_rdata = DATA_W'(ctrl_rd);
        else if (reg_addr == ADDR_W'(OFS_DATA))  reg_rdata = DATA_W'(rx_byte);
        else if (reg_addr == ADDR_W'(OFS_IMASK)) reg_rdata = imask;
    end

    p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ist && !load_ok |=> !irq)
        else $error("R3: status write left the interrupt raised");

    p_h2b_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> h2b)
        else $error("R4: load did not raise host-to-BMC attention");

    p_ctrl_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && reg_wdata[CB_CLR_WR] && !emitting |=> !emitting)
        else $error("R7: lower-priority emit acted beside a write-pointer clear");

    p_emit_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_EMIT && !emitting |=> emitting)
        else $error("R11: emit request did not start");

endmodule

// File: tb/bt_mbox_test.sv
`timescale 1ns/1ps
module bt_mbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ld_valid = 1'b0, ld_last = 1'b0;
    logic [7:0]  ld_data = '0;
    logic        ld_ready;
    logic        em_valid, em_last;
    logic        em_ready = 1'b0;
    logic [7:0]  em_data, em_seq;
    logic        irq;

    bt_mbox uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .ld_last(ld_last), .em_valid(em_valid), .em_ready(em_ready),
        .em_data(em_data), .em_last(em_last), .em_seq(em_seq), .irq(irq)
    );

    always #2 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit mon_on = 1'b0;

    // Behavioural reference state.
    logic [31:0] m_cfg0 = 0, m_ien = 0, m_ist = 0, m_cfg3 = 0, m_imask = 0;
    bit          m_h2b = 0, m_bbusy = 0, m_irq = 0, m_rpre = 1;
    int          m_rlen = 0, m_ridx = 0;
    logic [7:0]  m_rx[$];
    logic [7:0]  m_tx[$];
    logic [7:0]  q[$];

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] m_ctrl();
        return {24'h0, m_bbusy, 4'b0, m_h2b, 2'b0};
    endfunction

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        case (a)
            5'h00: m_cfg0 = d;
            5'h04: m_ien = d;
            5'h08: begin m_ist ^= d; m_irq = 0; end
            5'h0C: m_cfg3 = d;
            5'h18: m_imask = d;
            5'h14: if (m_tx.size() < 64) m_tx.push_back(d[7:0]);
            5'h10: begin
                if (d[0]) m_tx.delete();
                else if (d[1]) m_rpre = 1;
                else if (d[2]) m_h2b = 0;
                else if (d[7]) m_bbusy = ~m_bbusy;
                if (!m_bbusy) m_rlen = 0;
            end
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [4:0] a, input string r, input logic [31:0] extra = 0);
        logic [31:0] e;
        case (a)
            5'h00: e = m_cfg0;
            5'h04: e = m_ien;
            5'h08: e = m_ist;
            5'h0C: e = m_cfg3;
            5'h18: e = m_imask;
            5'h10: e = m_ctrl() | extra;
            5'h14: begin
                if (m_rpre) begin e = m_rlen; m_rpre = 0; m_ridx = 0; end
                else if (m_ridx < m_rlen) begin e = {24'h0, m_rx[m_ridx]}; m_ridx++; end
                else e = 0;
            end
            default: e = 0;
        endcase
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 chk(r, reg_rdata, e);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic host_load(input logic [7:0] b[$]);
        int n;
        n = b.size();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_data = b[i]; ld_last = (i == n - 1);
            @(posedge clk); #1;
        end
        ld_valid = 1'b0; ld_last = 1'b0;
        if (n >= 2) begin
            m_rx.delete();
            for (int i = 0; i < n && i < 64; i++) m_rx.push_back(b[i]);
            m_rlen = m_rx.size();
            m_h2b = 1; m_ist |= 1;
            if (m_ien[0]) m_irq = 1;
        end
    endtask

    task automatic emit_run(input string r, input bit stall);
        logic [7:0] e[$];
        logic [7:0] seq;
        int idx, cyc;
        seq = 0;
        if (m_tx.size() >= 3) begin
            seq = m_tx[2];
            m_tx[2] = m_tx[1];
            for (int i = 2; i < m_tx.size(); i++) e.push_back(m_tx[i]);
        end
        em_ready = 1'b0;
        wr_reg(5'h10, 32'h08);
        if (e.size() == 0) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); #1 chk({r, " no byte for short buffer"}, em_valid, 0);
            end
            rd_reg(5'h10, {r, " flags idle"});
            return;
        end
        rd_reg(5'h10, {r, " flags during emit"}, 32'h48);
        idx = 0; cyc = 0;
        while (idx < e.size() && cyc < 500) begin
            @(negedge clk);
            em_ready = stall ? (cyc % 3 != 0) : 1'b1;
            #1;
            chk({r, " valid"}, em_valid, 1);
            chk({r, " data (R12 hold)"}, em_data, e[idx]);
            chk({r, " last"}, em_last, idx == e.size() - 1);
            chk({r, " seq"}, em_seq, seq);
            if (em_ready && em_valid) idx++;
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        em_ready = 1'b0;
        #1 chk({r, " valid after last"}, em_valid, 0);
        rd_reg(5'h10, {r, " flags cleared"});
    endtask

    // Per-clock comparison of the interrupt line and load readiness.
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R3/R4 irq vs model", irq, m_irq);
            chk("R4 ld_ready vs busy", ld_ready, !m_bbusy);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        mon_on = 1'b1;

        // R1 reset state
        #1 chk("R1 irq", irq, 0);
        chk("R1 ld_ready", ld_ready, 1);
        chk("R1 em_valid", em_valid, 0);
        rd_reg(5'h00, "R1 cfg0"); rd_reg(5'h04, "R1 ien");
        rd_reg(5'h08, "R1 status"); rd_reg(5'h0C, "R1 cfg3");
        rd_reg(5'h10, "R1 ctrl"); rd_reg(5'h18, "R1 mask");
        rd_reg(5'h14, "R1 first data read is length 0");

        // R2 storage and unmapped offsets
        wr_reg(5'h00, 32'hA5A5_1234); wr_reg(5'h04, 32'hFFFF_0001);
        wr_reg(5'h0C, 32'h0BAD_F00D); wr_reg(5'h18, 32'h8000_0003);
        wr_reg(5'h1C, 32'hFFFF_FFFF); wr_reg(5'h02, 32'hFFFF_FFFF);
        rd_reg(5'h00, "R2 cfg0"); rd_reg(5'h04, "R2 ien");
        rd_reg(5'h0C, "R2 cfg3"); rd_reg(5'h18, "R2 mask");
        rd_reg(5'h1C, "R2 unmapped 0x1C"); rd_reg(5'h02, "R2 unaligned 0x02");
        rd_reg(5'h08, "R2 status untouched");

        // R4 host load
        q = '{8'h18, 8'h42, 8'h01, 8'h02, 8'h03};
        host_load(q);
        rd_reg(5'h10, "R4 attention set");
        rd_reg(5'h08, "R4 status bit0");
        #1 chk("R4 irq raised", irq, 1);

        // R3 status XOR and irq drop
        wr_reg(5'h08, 32'h1);  rd_reg(5'h08, "R3 clear bit0");
        #1 chk("R3 irq low", irq, 0);
        wr_reg(5'h08, 32'h30); rd_reg(5'h08, "R3 toggle on");
        wr_reg(5'h08, 32'h30); rd_reg(5'h08, "R3 toggle off");

        // R6 read-out with busy held (R8 keeps length)
        wr_reg(5'h10, 32'h80);
        rd_reg(5'h10, "R7 busy toggled on");
        #1 chk("R4 ld_ready low while busy", ld_ready, 0);
        wr_reg(5'h10, 32'h02);
        for (int i = 0; i < 8; i++) rd_reg(5'h14, "R6 data sequence");

        // R7 priority: bit2 beats bit7
        wr_reg(5'h10, 32'h84); rd_reg(5'h10, "R7 only attention cleared");
        wr_reg(5'h10, 32'h80); rd_reg(5'h10, "R7 busy toggled off");
        wr_reg(5'h10, 32'h02); rd_reg(5'h14, "R8 length zeroed");
        q = '{8'h20, 8'h07, 8'h09};
        host_load(q);
        wr_reg(5'h10, 32'h86); rd_reg(5'h10, "R7 rewind beats ack");
        rd_reg(5'h14, "R8 length zeroed after rewind");

        // R13 unhandled bits
        wr_reg(5'h10, 32'h70); rd_reg(5'h10, "R13 no effect");

        // R5 single-byte request rejected
        wr_reg(5'h10, 32'h04); wr_reg(5'h08, 32'h1);
        q = '{8'h55};
        host_load(q);
        rd_reg(5'h10, "R5 attention unchanged");
        rd_reg(5'h08, "R5 status unchanged");
        wr_reg(5'h10, 32'h80); wr_reg(5'h10, 32'h02);
        rd_reg(5'h14, "R5 length unchanged");
        wr_reg(5'h10, 32'h80);

        // R4 truncation at 64 bytes
        q.delete();
        for (int i = 0; i < 70; i++) q.push_back(8'(i + 1));
        host_load(q);
        wr_reg(5'h10, 32'h80); wr_reg(5'h10, 32'h02);
        for (int i = 0; i < 66; i++) rd_reg(5'h14, "R4 truncated read-out");
        wr_reg(5'h10, 32'h80); wr_reg(5'h10, 32'h04); wr_reg(5'h08, 32'h1);

        // R9/R11 emit with stalls, then re-emit showing slot-2 copy
        wr_reg(5'h10, 32'h01);
        wr_reg(5'h14, 32'h0000_0114); wr_reg(5'h14, 32'h5C);
        wr_reg(5'h14, 32'h33); wr_reg(5'h14, 32'hAA); wr_reg(5'h14, 32'hBB);
        emit_run("R11 stalled emit", 1'b1);
        emit_run("R11 re-emit", 1'b0);

        // R7 clear beats emit in one write; R10 empty buffer
        wr_reg(5'h10, 32'h09);
        @(negedge clk); #1 chk("R7 no emit beside clear", em_valid, 0);
        rd_reg(5'h10, "R7 flags after 0x09");
        emit_run("R10 empty after clear", 1'b0);

        // R9 overflow of the send buffer
        wr_reg(5'h10, 32'h01);
        for (int i = 0; i < 70; i++) wr_reg(5'h14, 32'(8'h80 + i));
        emit_run("R9 full buffer emit", 1'b0);

        // R11 two-byte buffer
        wr_reg(5'h10, 32'h01);
        wr_reg(5'h14, 32'h11); wr_reg(5'h14, 32'h22);
        emit_run("R11 short buffer", 1'b0);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule